// File: doc/BRIEF.md
# Digital Phase Lock Detector with Hysteresis

This block decides whether a phase-locked loop is in lock by watching the two edge streams that feed its phase comparator: the reference and the feedback-divider output. A fast sampling clock registers both streams and measures the gap between the paired rising edges of each comparison cycle in clock ticks. That gap is the phase error. The detector asserts lock only after a run of consecutive tight cycles. Once locked, it tolerates a wider error before it drops lock. This hysteresis keeps the indicator from chattering near the threshold.

Two independent detector channels, A and B, are built from one generated structure. Each channel has its own acquire threshold, its own divide-by-4 event thinning for fast comparison rates, and its own power-down input. A combining stage chooses what the single lock indicator reports: channel A, channel B, or the logical AND of both. Typical programmed values are an acquire threshold of 10 ticks for A and 15 ticks for B, at a 1 ns sampling period.

Top module: `lock_detect_pair`

## Requirements
- R1: The phase error of a comparison cycle is the number of sampling ticks between the first rising edge and its partner on the other input. Coincident edges give 0. A cycle is good when the error is strictly less than the acquire threshold. Lock asserts on the 5th consecutive good cycle and not before. The lock output changes on the second clock edge after the partner edge is sampled.
- R2: While unlocked, any cycle that is not good clears the run of good cycles, so 5 new good cycles are needed.
- R3: The hold threshold is twice the acquire threshold. While locked, lock drops only on a cycle whose error is strictly greater than the hold threshold, or on a timed-out cycle. An error equal to the hold threshold keeps lock. Lock never changes without a comparison event, power down or reset.
- R4: If the partner edge has not arrived 255 ticks after the first edge, the cycle closes as a timed-out cycle. A timed-out cycle counts as not good, and it drops lock when locked.
- R5: When the divide-by-4 control of a channel is 1, only every 4th completed comparison cycle is evaluated. These are the 4th, 8th and so on, counted from the moment the control is set. The other cycles have no effect on lock. When the control is 0, the phase count is held at zero.
- R6: While a channel's power-down input is 1, its lock output is 0 from the next clock edge on. Its run count, prescaler and any measurement in progress are cleared. After power-down is released, 5 new good cycles are needed to relock.
- R7: Mode 0 makes the lock indicator follow channel A. Mode 1 makes it follow channel B. Modes 2 and 3 make it high only when both channels are locked. The indicator is registered one cycle after the channel locks.
- R8: A synchronous active-high reset clears both channel locks, the combined indicator, the run counters, the prescalers and the measurement state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_a | input | 1 | Channel A reference edge stream |
| fb_a | input | 1 | Channel A divider edge stream |
| ref_b | input | 1 | Channel B reference edge stream |
| fb_b | input | 1 | Channel B divider edge stream |
| pd_a | input | 1 | Channel A power down |
| pd_b | input | 1 | Channel B power down |
| div4_a | input | 1 | Channel A divide-by-4 event thinning enable |
| div4_b | input | 1 | Channel B divide-by-4 event thinning enable |
| acq_thr_a | input | TW | Channel A acquire threshold in ticks |
| acq_thr_b | input | TW | Channel B acquire threshold in ticks |
| mode | input | 2 | Indicator source select |
| lock_a | output | 1 | Channel A lock |
| lock_b | output | 1 | Channel B lock |
| lock_out | output | 1 | Combined lock indicator |

## Verification
The hardest states to reach from the ports are the hold-window boundaries and the timed-out cycle. The hold-window boundaries need an already-locked channel that receives an error exactly equal to twice the acquire threshold, and then one tick more. The timed-out cycle needs a lone edge with no partner for 255 ticks. The stimulus first builds lock with directed runs of small errors. It then places edge pairs at exact tick gaps, and it sends an unpaired reference pulse followed by a long idle stretch. Seeded random gaps drawn from inside, between and beyond the two thresholds then exercise run resets, prescaled channels and combine modes, against a bench model of the counters.

// File: rtl/ld_pkg.sv
package ld_pkg;
  typedef enum logic [0:0] {
    MS_IDLE = 1'b0,
    MS_WAIT = 1'b1
  } meter_state_t;

  typedef enum logic [1:0] {
    SEL_A    = 2'd0,
    SEL_B    = 2'd1,
    SEL_BOTH = 2'd2,
    SEL_ALT  = 2'd3
  } sel_t;

  localparam int NUM_CH = 2;
endpackage

// File: rtl/ld_phase_meter.sv
module ld_phase_meter #(
  parameter int TMO = 255,
  localparam int CW = $clog2(TMO + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          ref_i,
  input  logic          fb_i,
  output logic          ev_v,
  output logic          ev_tmo,
  output logic [CW-1:0] ev_err
);
  import ld_pkg::*;

  meter_state_t  st;
  logic          ref_q, fb_q;
  logic          lead_ref;
  logic [CW-1:0] cnt;
  logic          ref_e, fb_e, partner;

  assign ref_e   = ref_i & ~ref_q;
  assign fb_e    = fb_i & ~fb_q;
  assign partner = lead_ref ? fb_e : ref_e;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      st       <= MS_IDLE;
      ref_q    <= 1'b0;
      fb_q     <= 1'b0;
      lead_ref <= 1'b0;
      cnt      <= '0;
      ev_v     <= 1'b0;
      ev_tmo   <= 1'b0;
      ev_err   <= '0;
    end else begin
      ref_q <= ref_i;
      fb_q  <= fb_i;
      ev_v  <= 1'b0;
      case (st)
        MS_IDLE: begin
          if (ref_e && fb_e) begin
            ev_v   <= 1'b1;
            ev_tmo <= 1'b0;
            ev_err <= '0;
          end else if (ref_e || fb_e) begin
            st       <= MS_WAIT;
            lead_ref <= ref_e;
            cnt      <= CW'(1);
          end
        end
        MS_WAIT: begin
          if (partner) begin
            ev_v   <= 1'b1;
            ev_tmo <= 1'b0;
            ev_err <= cnt;
            st     <= MS_IDLE;
          end else if (cnt == CW'(TMO)) begin
            ev_v   <= 1'b1;
            ev_tmo <= 1'b1;
            ev_err <= cnt;
            st     <= MS_IDLE;
          end else begin
            cnt <= cnt + CW'(1);
          end
        end
        default: st <= MS_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ld_event_thin.sv
module ld_event_thin #(
  parameter int RATIO = 4,
  localparam int PW = $clog2(RATIO)
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic thin_en,
  input  logic ev_in,
  output logic ev_out
);
  logic [PW-1:0] ph;

  assign ev_out = ev_in & (~thin_en | (ph == PW'(RATIO - 1)));

  always_ff @(posedge clk) begin
    if (rst || clr || !thin_en) begin
      ph <= '0;
    end else if (ev_in) begin
      ph <= (ph == PW'(RATIO - 1)) ? '0 : ph + PW'(1);
    end
  end
endmodule

// File: rtl/ld_hysteresis.sv
module ld_hysteresis #(
  parameter int TW = 8,
  parameter int CW = 8,
  parameter int GOOD_N = 5,
  localparam int EW = (CW > TW + 1) ? CW : TW + 1,
  localparam int GW = $clog2(GOOD_N + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          ev,
  input  logic          ev_tmo,
  input  logic [CW-1:0] ev_err,
  input  logic [TW-1:0] acq_thr,
  output logic          lock_o,
  output logic [GW-1:0] good_cnt
);
  logic [EW-1:0] err_x, acq_x, hold_x;
  logic          is_good, is_lost;

  assign err_x   = EW'(ev_err);
  assign acq_x   = EW'(acq_thr);
  assign hold_x  = EW'({acq_thr, 1'b0});
  assign is_good = !ev_tmo && (err_x < acq_x);
  assign is_lost = ev_tmo || (err_x > hold_x);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      lock_o   <= 1'b0;
      good_cnt <= '0;
    end else if (ev) begin
      if (!lock_o) begin
        if (!is_good) begin
          good_cnt <= '0;
        end else if (good_cnt == GW'(GOOD_N - 1)) begin
          lock_o   <= 1'b1;
          good_cnt <= '0;
        end else begin
          good_cnt <= good_cnt + GW'(1);
        end
      end else if (is_lost) begin
        lock_o   <= 1'b0;
        good_cnt <= '0;
      end
    end
  end
endmodule

// File: rtl/lock_detect_pair.sv
module lock_detect_pair #(
  parameter int TW = 8,
  parameter int TMO = 255,
  parameter int GOOD_N = 5,
  localparam int CW = $clog2(TMO + 1),
  localparam int GW = $clog2(GOOD_N + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ref_a,
  input  logic          fb_a,
  input  logic          ref_b,
  input  logic          fb_b,
  input  logic          pd_a,
  input  logic          pd_b,
  input  logic          div4_a,
  input  logic          div4_b,
  input  logic [TW-1:0] acq_thr_a,
  input  logic [TW-1:0] acq_thr_b,
  input  logic [1:0]    mode,
  output logic          lock_a,
  output logic          lock_b,
  output logic          lock_out
);
  import ld_pkg::*;

  logic [NUM_CH-1:0]   ref_v, fb_v, pd_v, d4_v, lk_v, ev_pass;
  logic [TW-1:0]       thr_v [NUM_CH];
  logic [GW-1:0]       good_v [NUM_CH];

  assign ref_v    = {ref_b, ref_a};
  assign fb_v     = {fb_b, fb_a};
  assign pd_v     = {pd_b, pd_a};
  assign d4_v     = {div4_b, div4_a};
  assign thr_v[0] = acq_thr_a;
  assign thr_v[1] = acq_thr_b;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic          m_v, m_tmo;
    logic [CW-1:0] m_err;

    ld_phase_meter #(.TMO(TMO)) u_meter (
      .clk(clk), .rst(rst), .clr(pd_v[g]),
      .ref_i(ref_v[g]), .fb_i(fb_v[g]),
      .ev_v(m_v), .ev_tmo(m_tmo), .ev_err(m_err)
    );

    ld_event_thin #(.RATIO(4)) u_thin (
      .clk(clk), .rst(rst), .clr(pd_v[g]),
      .thin_en(d4_v[g]), .ev_in(m_v), .ev_out(ev_pass[g])
    );

    ld_hysteresis #(.TW(TW), .CW(CW), .GOOD_N(GOOD_N)) u_hyst (
      .clk(clk), .rst(rst), .clr(pd_v[g]),
      .ev(ev_pass[g]), .ev_tmo(m_tmo), .ev_err(m_err),
      .acq_thr(thr_v[g]), .lock_o(lk_v[g]), .good_cnt(good_v[g])
    );
  end

  assign lock_a = lk_v[0];
  assign lock_b = lk_v[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      lock_out <= 1'b0;
    end else begin
      case (sel_t'(mode))
        SEL_A:   lock_out <= lk_v[0];
        SEL_B:   lock_out <= lk_v[1];
        default: lock_out <= &lk_v;
      endcase
    end
  end
endmodule

// File: rtl/lock_detect_pair_chk.sv
module lock_detect_pair_chk #(
  parameter int GOOD_N = 5,
  parameter int GW = 3
) (
  input logic          clk,
  input logic          rst,
  input logic          pd_a,
  input logic          pd_b,
  input logic [1:0]    mode,
  input logic          lock_a,
  input logic          lock_b,
  input logic          lock_out,
  input logic [1:0]    ev_pass,
  input logic [GW-1:0] good_a
);
  assert_pd_low_R6: assert property (@(posedge clk) disable iff (rst)
    pd_a |=> !lock_a);

  assert_pd_low_b_R6: assert property (@(posedge clk) disable iff (rst)
    pd_b |=> !lock_b);

  assert_both_R7: assert property (@(posedge clk) disable iff (rst)
    (mode[1] && !(lock_a && lock_b)) |=> !lock_out);

  assert_follow_a_R7: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'd0) |=> (lock_out == $past(lock_a)));

  assert_quiet_R3: assert property (@(posedge clk) disable iff (rst)
    (!ev_pass[0] && !pd_a) |=> $stable(lock_a));

  assert_run_bound_R1: assert property (@(posedge clk) disable iff (rst)
    good_a < GW'(GOOD_N));

  assert_reset_R8: assert property (@(posedge clk)
    rst |=> (!lock_a && !lock_b && !lock_out));
endmodule

bind lock_detect_pair lock_detect_pair_chk #(.GOOD_N(GOOD_N), .GW(GW)) u_chk (
  .clk(clk), .rst(rst), .pd_a(pd_a), .pd_b(pd_b), .mode(mode),
  .lock_a(lock_a), .lock_b(lock_b), .lock_out(lock_out),
  .ev_pass(ev_pass), .good_a(good_v[0])
);

// File: tb/sim_lock_detect_pair.sv
module sim_lock_detect_pair;
  localparam int CLK_T = 10;
  localparam int TW = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0] rf = '0, fb = '0, pd = '0, d4 = '0;
  logic [TW-1:0] thr [2];
  logic [1:0] mode = 2'd0;
  logic lock_a, lock_b, lock_out;

  int total = 0;
  int bad = 0;

  int m_lock [2];
  int m_cnt  [2];
  int m_ph   [2];

  always #(CLK_T/2) clk = ~clk;

  lock_detect_pair #(.TW(TW), .TMO(255), .GOOD_N(5)) u0 (
    .clk(clk), .rst(rst),
    .ref_a(rf[0]), .fb_a(fb[0]), .ref_b(rf[1]), .fb_b(fb[1]),
    .pd_a(pd[0]), .pd_b(pd[1]), .div4_a(d4[0]), .div4_b(d4[1]),
    .acq_thr_a(thr[0]), .acq_thr_b(thr[1]), .mode(mode),
    .lock_a(lock_a), .lock_b(lock_b), .lock_out(lock_out)
  );

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int exp_out();
    case (mode)
      2'd0:    return m_lock[0];
      2'd1:    return m_lock[1];
      default: return m_lock[0] & m_lock[1];
    endcase
  endfunction

  function automatic void mdl_clear(int ch);
    m_lock[ch] = 0;
    m_cnt[ch]  = 0;
    m_ph[ch]   = 0;
  endfunction

  function automatic void mdl_event(int ch, int gap);
    bit tmo = (gap > 255);
    bit pass;
    if (d4[ch]) begin
      pass = (m_ph[ch] == 3);
      m_ph[ch] = (m_ph[ch] + 1) % 4;
    end else begin
      pass = 1;
      m_ph[ch] = 0;
    end
    if (!pass) return;
    if (m_lock[ch] == 0) begin
      if (!tmo && gap < int'(thr[ch])) begin
        if (m_cnt[ch] == 4) begin m_lock[ch] = 1; m_cnt[ch] = 0; end
        else m_cnt[ch]++;
      end else m_cnt[ch] = 0;
    end else if (tmo || gap > 2 * int'(thr[ch])) begin
      m_lock[ch] = 0;
      m_cnt[ch] = 0;
    end
  endfunction

  // gap > 255 sends a lone edge (timeout cycle)
  task automatic cmp(int ch, int gap, bit lead_ref, string tag);
    @(negedge clk);
    if (gap == 0) begin rf[ch] = 1; fb[ch] = 1; end
    else if (lead_ref) rf[ch] = 1;
    else fb[ch] = 1;
    @(negedge clk);
    rf[ch] = 0; fb[ch] = 0;
    if (gap > 255) begin
      repeat (258) @(negedge clk);
    end else if (gap > 0) begin
      repeat (gap - 1) @(negedge clk);
      if (lead_ref) fb[ch] = 1; else rf[ch] = 1;
      @(negedge clk);
      rf[ch] = 0; fb[ch] = 0;
    end
    repeat (4) @(negedge clk);
    mdl_event(ch, gap);
    chk(tag, (ch == 0) ? int'(lock_a) : int'(lock_b), m_lock[ch]);
    chk("R7", int'(lock_out), exp_out());
  endtask

  task automatic power_cycle(int ch);
    @(negedge clk);
    pd[ch] = 1;
    @(negedge clk);
    chk("R6", (ch == 0) ? int'(lock_a) : int'(lock_b), 0);
    @(negedge clk);
    pd[ch] = 0;
    mdl_clear(ch);
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd7321));
    thr[0] = 8'd10;
    thr[1] = 8'd15;
    mdl_clear(0);
    mdl_clear(1);
    repeat (3) @(negedge clk);
    chk("R8", int'(lock_a), 0);
    chk("R8", int'(lock_b), 0);
    chk("R8", int'(lock_out), 0);
    rst = 0;

    // R1: four good cycles are not enough
    for (int i = 0; i < 4; i++) cmp(0, 3, i[0], "R1");
    // R2: error equal to acquire threshold is not good
    cmp(0, 10, 1, "R2");
    cmp(0, 0, 1, "R2");
    cmp(0, 9, 0, "R2");
    cmp(0, 5, 1, "R2");
    cmp(0, 2, 0, "R2");
    cmp(0, 1, 1, "R1");
    // R3: hysteresis window
    cmp(0, 15, 1, "R3");
    cmp(0, 20, 0, "R3");
    cmp(0, 21, 1, "R3");
    // R4: relock then a lone edge times out
    for (int i = 0; i < 5; i++) cmp(0, 4, 1, "R1");
    cmp(0, 300, 1, "R4");
    // R6: power down and fresh reacquisition
    for (int i = 0; i < 5; i++) cmp(0, 2, 0, "R1");
    power_cycle(0);
    for (int i = 0; i < 5; i++) cmp(0, 6, 1, "R6");

    // R7: combine modes
    for (int i = 0; i < 5; i++) cmp(1, 14, 0, "R1");
    mode = 2'd2; repeat (3) @(negedge clk); chk("R7", int'(lock_out), exp_out());
    cmp(0, 40, 1, "R3");
    mode = 2'd3; repeat (3) @(negedge clk); chk("R7", int'(lock_out), exp_out());
    mode = 2'd1; repeat (3) @(negedge clk); chk("R7", int'(lock_out), exp_out());

    // R5: divide-by-4 on channel B, bad errors only count on the fourth
    d4[1] = 1;
    for (int i = 0; i < 4; i++) cmp(1, 40, 1, "R5");
    for (int i = 0; i < 20; i++) cmp(1, 3, 0, "R5");
    d4[1] = 0;

    // random mix
    for (int i = 0; i < 80; i++) begin
      int ch = $urandom % 2;
      int a = int'(thr[ch]);
      int r = $urandom % 8;
      int gap;
      if (r < 4) gap = $urandom % a;
      else if (r < 6) gap = a + ($urandom % (a + 1));
      else if (r < 7) gap = 2 * a + 1 + ($urandom % 20);
      else gap = ($urandom % 6 == 0) ? 300 : $urandom % a;
      if ($urandom % 16 == 0) d4[ch] = ~d4[ch];
      if (d4[ch] == 0) m_ph[ch] = 0;
      mode = 2'($urandom % 4);
      if ($urandom % 25 == 0) power_cycle(ch);
      cmp(ch, gap, 1'($urandom % 2), d4[ch] ? "R5" : "R3");
    end

    // R8: reset mid-run
    d4 = '0;
    mode = 2'd2;
    for (int i = 0; i < 5; i++) cmp(0, 1, 1, "R1");
    for (int i = 0; i < 5; i++) cmp(1, 1, 0, "R1");
    @(negedge clk); rst = 1;
    repeat (2) @(negedge clk);
    mdl_clear(0); mdl_clear(1);
    chk("R8", int'(lock_a), 0);
    chk("R8", int'(lock_b), 0);
    chk("R8", int'(lock_out), 0);
    rst = 0;
    for (int i = 0; i < 4; i++) cmp(0, 1, 1, "R8");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule